// File: doc/BRIEF.md
# Pipelined No-Wait Burst Static Memory

A single-port synchronous memory whose bus is pipelined so that reads and writes may follow each other on consecutive clocks with no turnaround slot. Every synchronous input is captured on the rising clock edge. An access either loads a new external address or, with the advance input high, steps a two-bit burst counter over the low address bits. The counter follows an incrementing order or an XOR order, chosen by a mode input.

A read returns its word on the second accepted edge after its command. A write takes its data from the bus on the second accepted edge after its command, which is why a write can follow a read at once. Per-byte write strobes are active low. Three chip selects must all be in their active state for a new access to start. An active-low clock enable freezes the whole block for a cycle. A sleep input freezes it, after a two-cycle lag, and turns the output drive off.

A read aimed at a word whose write is still in flight returns the new bytes merged over the stored ones. The read-data output comes as a value and a drive-enable pair, so that a pad ring can build a shared bus from it.

Top module: `nwsram`

## Requirements
- R1: After reset the block is deselected and does not drive, and an advance cycle issued before any new access stays deselected.
- R2: A new access starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 with `adv`=0. Any other combination is a deselect that drives nothing. Advance cycles after a deselect remain deselected.
- R3: With `adv`=0, the address is loaded and a read (`wr_n`=1) or a write (`wr_n`=0) begins. Read data is registered on the second accepted edge after the command. Write data is taken from `wdata` on that same second accepted edge.
- R4: With `burst_ilv`=0, an advance cycle uses low address bits (start + step) mod 4, where step counts 1, 2, 3, 0 from the load. The upper bits stay the same.
- R5: With `burst_ilv`=1, the low address bits are start XOR step.
- R6: `bwe_n[i]`=0 writes bits [8i+7:8i]. A write with every strobe high changes nothing, and the burst counter still steps.
- R7: Reads and writes may alternate on consecutive accepted edges with no idle cycle.
- R8: A read sees every write issued before it, including a write still in the pipeline, merged byte by byte.
- R9: With `clk_en_n`=1 all inputs are ignored and every register, including `rdata`, keeps its value.
- R10: `rdata_oe` is high only for a read result while `out_en_n`=0. Writes and reads with `out_en_n`=1 do not drive.
- R11: When `sleep` is high at an edge, commands at that edge and the next are still accepted, and later ones are ignored. When it falls, commands are accepted again from the second edge after it falls. While the block is asleep, `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Low to accept the edge, high to freeze |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | High steps the burst, low loads a new address |
| wr_n | input | 1 | Low starts a write, high a read |
| bwe_n | input | DW/LANE_W | Byte write strobes, active low |
| burst_ilv | input | 1 | Burst order: 1 XOR, 0 incrementing |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, two accepted edges after its command |
| out_en_n | input | 1 | Output drive enable, active low |
| sleep | input | 1 | Sleep request |
| rdata | output | DW | Registered read data |
| rdata_oe | output | 1 | High when rdata should be driven onto the bus |

## Verification
The bench writes bursts from start offset 01 in both orders, then reads them back. Under the wrong order the readback shows the wrong lane words, and an XOR read starting at 11 separates the two orders where a start of 10 would not. A write followed at once by a read of the same word separates forwarded data from stale data, and partial strobes show whether the merge is done per lane. A gap of one cycle moves the same case onto the array path. The remaining tests check that inputs are ignored or drive is held off. They issue a write or a read during a suspend, while asleep, with a non-selecting chip-select combination, or with the output enable high. A later readback, or the drive-enable state itself, then shows whether the stimulus leaked through.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

  // burst counter width (low address bits walked by a burst)
  localparam int BCW = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits for a given step of a burst
  function automatic logic [BCW-1:0] burst_low(
    input logic [BCW-1:0] start,
    input logic [BCW-1:0] idx,
    input logic           ilv
  );
    return ilv ? (start ^ idx) : (start + idx);
  endfunction

endpackage

// File: rtl/nwsram_sleep.sv
module nwsram_sleep #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic asleep
);
  logic [LAG-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[LAG-2:0], sleep};
  end

  assign asleep = sh_q[LAG-1];
endmodule

// File: rtl/nwsram_ctl.sv
module nwsram_ctl
  import nwsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           adv,
  input  logic           sel_ok,
  input  logic           wr_n,
  input  logic           ilv,
  input  logic [AW-1:0]  addr,
  output op_e            iss_op,
  output logic [AW-1:0]  iss_addr,
  output logic [BCW-1:0] step_q
);
  op_e            last_q;
  logic [AW-1:0]  base_q;
  logic [BCW-1:0] step_n;
  logic           load;

  always_comb begin
    load   = !adv;
    step_n = load ? '0 : step_q + BCW'(1);
    if (load) iss_op = sel_ok ? (wr_n ? OP_RD : OP_WR) : OP_IDLE;
    else      iss_op = last_q;
    if (load) iss_addr = addr;
    else      iss_addr = {base_q[AW-1:BCW], burst_low(base_q[BCW-1:0], step_n, ilv)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= OP_IDLE;
      base_q <= '0;
      step_q <= '0;
    end else if (tick) begin
      last_q <= iss_op;
      step_q <= step_n;
      if (load) base_q <= addr;
    end
  end
endmodule

// File: rtl/nwsram_array.sv
module nwsram_array #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW/LW-1:0] wr_mask,
  input  logic [DW-1:0] wr_data
);
  localparam int NB    = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, read-first, byte write enables
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
    if (wr_en) begin
      for (int g = 0; g < NB; g++) begin
        if (wr_mask[g]) mem[wr_addr][g*LW +: LW] <= wr_data[g*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/nwsram_pipe.sv
module nwsram_pipe
  import nwsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  op_e              iss_op,
  input  logic [AW-1:0]    iss_addr,
  input  logic [DW/LW-1:0] iss_bwn,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    rd_q,
  output logic [AW-1:0]    rd_addr,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW/LW-1:0] wr_mask,
  output logic             drive_q,
  output logic [DW-1:0]    rdata_q
);
  localparam int NB = DW / LW;

  op_e           s1_op, s2_op;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_msk, s2_msk, s2_fmsk;
  logic [DW-1:0] s2_fdat, merged;

  // per-lane merge of forwarded write data over the array word
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[g*LW +: LW] = s2_fmsk[g] ? s2_fdat[g*LW +: LW] : rd_q[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s2_fmsk <= '0;
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else if (tick) begin
      s1_op   <= iss_op;
      s1_addr <= iss_addr;
      s1_msk  <= ~iss_bwn;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_msk  <= s1_msk;
      // the write leaving stage 2 commits on the same edge the array is read
      s2_fmsk <= (s2_op == OP_WR && s2_addr == s1_addr) ? s2_msk : '0;
      s2_fdat <= wdata;
      drive_q <= (s2_op == OP_RD);
      if (s2_op == OP_RD) rdata_q <= merged;
    end
  end

  assign rd_addr = s1_addr;
  assign wr_en   = tick && (s2_op == OP_WR);
  assign wr_addr = s2_addr;
  assign wr_mask = s2_msk;
endmodule

// File: rtl/nwsram.sv
module nwsram
  import nwsram_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int LANE_W    = 8,
  parameter int SLEEP_LAG = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en_n,
  input  logic                 sel_a_n,
  input  logic                 sel_b,
  input  logic                 sel_c_n,
  input  logic                 adv,
  input  logic                 wr_n,
  input  logic [DW/LANE_W-1:0] bwe_n,
  input  logic                 burst_ilv,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 out_en_n,
  input  logic                 sleep,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_oe
);
  localparam int NB = DW / LANE_W;

  logic           asleep, tick, sel_ok, drive_q, arr_wr_en;
  op_e            iss_op;
  logic [AW-1:0]  iss_addr, arr_rd_addr, arr_wr_addr;
  logic [NB-1:0]  arr_wr_mask;
  logic [DW-1:0]  arr_rd_q, rdata_q;
  logic [BCW-1:0] step_q;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
  assign tick   = !clk_en_n && !asleep;

  nwsram_sleep #(.LAG(SLEEP_LAG)) u_sleep (
    .clk(clk), .rst(rst), .sleep(sleep), .asleep(asleep)
  );

  nwsram_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .tick(tick), .adv(adv), .sel_ok(sel_ok),
    .wr_n(wr_n), .ilv(burst_ilv), .addr(addr),
    .iss_op(iss_op), .iss_addr(iss_addr), .step_q(step_q)
  );

  nwsram_pipe #(.AW(AW), .DW(DW), .LW(LANE_W)) u_pipe (
    .clk(clk), .rst(rst), .tick(tick), .iss_op(iss_op), .iss_addr(iss_addr),
    .iss_bwn(bwe_n), .wdata(wdata), .rd_q(arr_rd_q),
    .rd_addr(arr_rd_addr), .wr_en(arr_wr_en), .wr_addr(arr_wr_addr),
    .wr_mask(arr_wr_mask), .drive_q(drive_q), .rdata_q(rdata_q)
  );

  nwsram_array #(.AW(AW), .DW(DW), .LW(LANE_W)) u_array (
    .clk(clk), .rd_en(tick), .rd_addr(arr_rd_addr), .rd_q(arr_rd_q),
    .wr_en(arr_wr_en), .wr_addr(arr_wr_addr), .wr_mask(arr_wr_mask),
    .wr_data(wdata)
  );

  assign rdata    = rdata_q;
  assign rdata_oe = drive_q && !out_en_n && !asleep;
endmodule

// File: rtl/nwsram_chk.sv
module nwsram_chk
  import nwsram_pkg::*;
#(
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           clk_en_n,
  input logic           out_en_n,
  input logic           adv,
  input logic           tick,
  input logic           asleep,
  input logic           drive_q,
  input logic           arr_wr_en,
  input logic [BCW-1:0] step_q,
  input logic [DW-1:0]  rdata,
  input logic           rdata_oe
);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(rdata) && $stable(drive_q));

  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    asleep |=> $stable(rdata));

  a_r11_no_drive: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !rdata_oe);

  a_r10_oe_gate: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> !out_en_n);

  a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en |=> !drive_q);

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (tick && adv) |=> step_q == BCW'($past(step_q) + 1'b1));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (tick && !adv) |=> step_q == '0);
endmodule

bind nwsram nwsram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .out_en_n(out_en_n), .adv(adv),
  .tick(tick), .asleep(asleep), .drive_q(drive_q), .arr_wr_en(arr_wr_en),
  .step_q(step_q), .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/nwsram_test.sv
`timescale 1ns/1ps
module nwsram_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        adv = 1'b0, wr_n = 1'b1, burst_ilv = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
  logic [3:0]  bwe_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_oe;

  always #10 clk = ~clk;  // 50 MHz

  nwsram uut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .wr_n(wr_n), .bwe_n(bwe_n), .burst_ilv(burst_ilv),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] shadow [0:255];
  int          m_last = 0;
  logic [7:0]  m_base = '0;
  logic [1:0]  m_step = '0;
  bit          b_s1 = 0, b_s2 = 0;
  bit          e1_rd = 0, e2_rd = 0, sh_rd = 0;
  logic [31:0] e1_dat = '0, e2_dat = '0, sh_dat = '0;
  string       e1_tag = "R1", e2_tag = "R1", sh_tag = "R1";
  logic [31:0] w1 = '0, w2 = '0;

  // scoreboard queues
  bit          q_rd [$];
  logic [31:0] q_dat [$];
  string       q_tag [$];

  task automatic issue(input logic a_n, input logic b, input logic c_n,
                       input logic advv, input logic wrn, input logic [3:0] bwn,
                       input logic [7:0] ad, input logic [31:0] wd, input string tag);
    int op; logic [7:0] a; logic [1:0] st; bit act;
    @(negedge clk);
    sel_a_n = a_n; sel_b = b; sel_c_n = c_n; adv = advv; wr_n = wrn;
    bwe_n = bwn; addr = ad; wdata = w2;
    act = !clk_en_n && !b_s2;
    if (!advv) begin
      op = (!a_n && b && !c_n) ? (wrn ? 1 : 2) : 0;
      a = ad; st = 2'd0;
    end else begin
      op = m_last; st = m_step + 2'd1;
      a = {m_base[7:2], burst_ilv ? (m_base[1:0] ^ st) : (m_base[1:0] + st)};
    end
    @(posedge clk); #1;
    b_s2 = b_s1; b_s1 = sleep;
    if (act) begin
      if (op == 2)
        for (int l = 0; l < 4; l++)
          if (!bwn[l]) shadow[a][l*8 +: 8] = wd[l*8 +: 8];
      sh_rd = e2_rd; sh_dat = e2_dat; sh_tag = e2_tag;
      e2_rd = e1_rd; e2_dat = e1_dat; e2_tag = e1_tag;
      e1_rd = (op == 1); e1_dat = shadow[a]; e1_tag = tag;
      w2 = w1; w1 = wd;
      m_last = op; m_step = st;
      if (!advv) m_base = ad;
    end else begin
      sh_tag = sleep || b_s1 || b_s2 ? "R11" : "R9";
    end
    q_rd.push_back(sh_rd); q_dat.push_back(sh_dat); q_tag.push_back(sh_tag);
  endtask

  task automatic rd(input logic [7:0] ad, input string tag);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, ad, 32'h0, tag);
  endtask
  task automatic wr(input logic [7:0] ad, input logic [31:0] d, input logic [3:0] bwn, input string tag);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bwn, ad, d, tag);
  endtask
  task automatic cn(input logic [31:0] d, input logic [3:0] bwn, input string tag);
    issue(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, bwn, 8'h00, d, tag);
  endtask
  task automatic ds(input logic a_n, input logic b, input logic c_n, input string tag);
    issue(a_n, b, c_n, 1'b0, 1'b1, 4'hF, 8'h00, 32'h0, tag);
  endtask

  // monitor: compares outputs well away from the clock edge
  bit          m_rd, exp_oe;
  logic [31:0] m_dat;
  string       m_tag;
  always @(posedge clk) begin
    #5;
    if (q_rd.size() > 0) begin
      m_rd = q_rd.pop_front(); m_dat = q_dat.pop_front(); m_tag = q_tag.pop_front();
      exp_oe = m_rd && !out_en_n && !b_s2;
      nvec++;
      if (rdata_oe !== exp_oe) begin
        nbad++;
        $display("FAIL %s: rdata_oe actual %b expected %b", m_tag, rdata_oe, exp_oe);
      end else if (exp_oe && rdata !== m_dat) begin
        nbad++;
        $display("FAIL %s: rdata actual %h expected %h", m_tag, rdata, m_dat);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R3 watchdog: actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #5;
    nvec++;
    if (rdata_oe !== 1'b0) begin
      nbad++;
      $display("FAIL R1: rdata_oe actual %b expected 0 after reset", rdata_oe);
    end

    // R1: advance cycle straight after reset stays deselected
    cn(32'h0, 4'hF, "R1"); cn(32'h0, 4'hF, "R1");

    // prefill
    wr(8'h30, 32'hA0A0_0000, 4'h0, "R3"); cn(32'hA1A1_0001, 4'h0, "R3");
    cn(32'hA2A2_0002, 4'h0, "R3"); cn(32'hA3A3_0003, 4'h0, "R3");
    wr(8'h40, 32'hB0B0_0040, 4'h0, "R3");

    // R4: incrementing burst from offset 01
    wr(8'h11, 32'hC0C0_1111, 4'h0, "R4"); cn(32'hC1C1_1212, 4'h0, "R4");
    cn(32'hC2C2_1313, 4'h0, "R4"); cn(32'hC3C3_1010, 4'h0, "R4");
    rd(8'h11, "R7"); cn(32'h0, 4'hF, "R4"); cn(32'h0, 4'hF, "R4"); cn(32'h0, 4'hF, "R4");

    // R8: read right behind a partial write, then one cycle apart
    wr(8'h12, 32'hD0D1_D2D3, 4'b1010, "R8"); rd(8'h12, "R8");
    wr(8'h13, 32'hDDDD_1313, 4'h0, "R8"); ds(1'b1, 1'b1, 1'b0, "R8"); rd(8'h13, "R8");

    // R7: alternate reads and writes every cycle
    rd(8'h30, "R7"); wr(8'h31, 32'hE0E0_3131, 4'h0, "R7"); rd(8'h31, "R7");
    wr(8'h30, 32'hE1E1_3030, 4'h0, "R7"); rd(8'h30, "R7"); rd(8'h31, "R7");

    // R5: XOR order, write from 01 and read from 11
    burst_ilv = 1'b1;
    wr(8'h21, 32'hF0F0_2121, 4'h0, "R5"); cn(32'hF1F1_2020, 4'h0, "R5");
    cn(32'hF2F2_2323, 4'h0, "R5"); cn(32'hF3F3_2222, 4'h0, "R5");
    rd(8'h23, "R5"); cn(32'h0, 4'hF, "R5"); cn(32'h0, 4'hF, "R5"); cn(32'h0, 4'hF, "R5");
    burst_ilv = 1'b0;

    // R6: abort in the middle of a burst, single-lane write
    wr(8'h30, 32'h6060_6060, 4'h0, "R6"); cn(32'h6161_6161, 4'hF, "R6");
    cn(32'h6262_6262, 4'h0, "R6"); wr(8'h33, 32'h7700_0000, 4'b0111, "R6");
    rd(8'h30, "R6"); cn(32'h0, 4'hF, "R6"); cn(32'h0, 4'hF, "R6"); cn(32'h0, 4'hF, "R6");

    // R2: non-selecting combinations with a read attempt, then advance
    ds(1'b1, 1'b1, 1'b0, "R2"); cn(32'h0, 4'hF, "R2");
    ds(1'b0, 1'b0, 1'b0, "R2"); cn(32'h0, 4'hF, "R2");
    ds(1'b0, 1'b1, 1'b1, "R2"); cn(32'h0, 4'hF, "R2"); cn(32'h0, 4'hF, "R2");

    // R9: suspend with reads in flight and a write that must be ignored
    rd(8'h11, "R9"); rd(8'h12, "R9");
    clk_en_n = 1'b1;
    wr(8'h40, 32'h9999_9999, 4'h0, "R9"); wr(8'h40, 32'h9999_9999, 4'h0, "R9");
    clk_en_n = 1'b0;
    ds(1'b1, 1'b1, 1'b0, "R9"); ds(1'b1, 1'b1, 1'b0, "R9");
    rd(8'h40, "R9"); ds(1'b1, 1'b1, 1'b0, "R9"); ds(1'b1, 1'b1, 1'b0, "R9");

    // R10: dummy read with output enable off
    out_en_n = 1'b1;
    rd(8'h11, "R10"); ds(1'b1, 1'b1, 1'b0, "R10"); ds(1'b1, 1'b1, 1'b0, "R10");
    out_en_n = 1'b0;
    ds(1'b1, 1'b1, 1'b0, "R10");

    // R11: sleep entry and exit
    sleep = 1'b1;
    rd(8'h32, "R11"); ds(1'b1, 1'b1, 1'b0, "R11");
    wr(8'h32, 32'h5555_5555, 4'h0, "R11");
    ds(1'b1, 1'b1, 1'b0, "R11"); ds(1'b1, 1'b1, 1'b0, "R11");
    sleep = 1'b0;
    wr(8'h32, 32'h5656_5656, 4'h0, "R11"); ds(1'b1, 1'b1, 1'b0, "R11");
    rd(8'h32, "R11"); ds(1'b1, 1'b1, 1'b0, "R11");
    ds(1'b1, 1'b1, 1'b0, "R11"); ds(1'b1, 1'b1, 1'b0, "R11");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule